// File: doc/BRIEF.md
# Strobe-Framed Serial Word Receiver

This block takes in a message of 16-bit words from a synchronous serial link. The link has three wires: a serial clock, a data line and a framing strobe. Each of the three is passed through a two-stage synchronizer into the system clock domain, and the block detects edges there. While the strobe is high, every falling edge of the serial clock captures one data bit, least significant bit first.

Sixteen bits make a word. When parity is enabled, a seventeenth bit follows, and the selected parity is checked over all seventeen bits. Each complete word goes to the write side of an external receive FIFO. A message can hold any number of words, and it ends when the strobe falls.

The block keeps four sticky error flags: parity, framing, overrun and word count. Each flag stays set until software clears it through a per-bit clear mask. The block also counts the words of the current message, raises a one-cycle end-of-message interrupt, and passes through one synchronized user input bit.

Top module: `strobe_word_rx`

## Requirements
- R1: While the strobe is high, a data bit is captured on each falling serial clock edge. The first captured bit becomes bit 0 of the word and the 16th becomes bit 15.
- R2: With parity off, a word is 16 bits. With parity on, a 17th bit (the parity bit) follows, and the word is written without it.
- R3: `par_mode_i` selects the parity check: 0 = off, 1 = odd (the ones among the 17 bits must be odd), 2 = even (they must be even), 3 = off. A mismatch sets `err_o[0]`, and the word is still written.
- R4: Error flags are sticky. A flag stays set until a cycle in which the matching `clr_err_i` bit is high. A flag being set in that same cycle takes priority over the clear.
- R5: If the strobe falls while a partial word is held, `err_o[1]` (frame) is set and the partial word is dropped.
- R6: If a word completes while `fifo_full_i` is high, that word is not written and `err_o[2]` (overrun) is set.
- R7: When the strobe falls, if `exp_count_i` is nonzero and differs from the number of words completed in the message, `err_o[3]` (word count) is set. A zero `exp_count_i` disables this check.
- R8: `eom_irq_o` pulses high for exactly one cycle for each falling edge of the strobe.
- R9: `word_cnt_o` is cleared when the strobe rises. It counts every completed word, including dropped ones, and holds its value after the message ends.
- R10: `user_bit_o` follows `user_bit_i` after synchronization.
- R11: After reset, `fifo_wr_o`, `err_o`, `eom_irq_o` and `word_cnt_o` are all zero.
- R12: A word whose last bit is captured in the same cycle the strobe falls counts as complete. It is written and counted, and it causes no frame error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial link clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, stable around the falling clock edge |
| ser_stb_i | input | 1 | Message framing strobe |
| user_bit_i | input | 1 | General-purpose user input |
| par_mode_i | input | 2 | Parity mode: 0 off, 1 odd, 2 even, 3 off |
| exp_count_i | input | CNT_W | Expected words per message; 0 disables the check |
| clr_err_i | input | 4 | Per-bit clear mask for `err_o` |
| fifo_full_i | input | 1 | Receive FIFO full |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | DATA_W | Word to write |
| err_o | output | 4 | Sticky errors: [0] parity, [1] frame, [2] overrun, [3] word count |
| word_cnt_o | output | CNT_W | Words completed in the current or last message |
| eom_irq_o | output | 1 | End-of-message pulse |
| user_bit_o | output | 1 | Synchronized user bit |

## Verification
Completing a word and ending a message can happen in the same system cycle. This occurs when the strobe falls together with the serial clock edge that carries the final bit. The bench provokes it by dropping the strobe at that falling edge instead of half a clock later. It then judges that the word was written and counted, that no frame error was raised, and that a matching expected count gives no word-count error.

// File: rtl/strobe_rx_pkg.sv
package strobe_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_EVEN  = 2'd2,
        PAR_NONE2 = 2'd3
    } par_mode_e;

    // Bit order gives err_o[0]=parity ... err_o[3]=word count
    typedef struct packed {
        logic cnt;
        logic ovr;
        logic frm;
        logic par;
    } rx_err_t;

    localparam int unsigned ERR_W = $bits(rx_err_t);

    function automatic logic par_enabled(input par_mode_e m);
        return (m == PAR_ODD) || (m == PAR_EVEN);
    endfunction

    // data_x: xor of data bits, pbit: received parity bit
    function automatic logic parity_bad(input par_mode_e m, input logic data_x,
                                        input logic pbit);
        logic total;
        total = data_x ^ pbit;
        case (m)
            PAR_ODD:  return (total == 1'b0);
            PAR_EVEN: return (total == 1'b1);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES+1];

    assign chain[0] = d_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g+1] <= '0;
            else     chain[g+1] <= chain[g];
        end
    end

    assign q_o = chain[STAGES];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import strobe_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb_i,
    input  logic              bit_val_i,
    input  logic              flush_i,
    input  par_mode_e         par_mode_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              par_err_o,
    output logic              partial_o
);
    localparam int unsigned BC_W = $clog2(DATA_W + 2);

    logic [BC_W-1:0]   bit_cnt, cnt_nxt, last_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_on, is_last;

    always_comb begin
        par_on    = par_enabled(par_mode_i);
        last_idx  = par_on ? BC_W'(DATA_W) : BC_W'(DATA_W - 1);
        is_last   = bit_stb_i && (bit_cnt == last_idx);
        data_o    = par_on ? shreg : {bit_val_i, shreg[DATA_W-1:1]};
        par_err_o = par_on && parity_bad(par_mode_i, ^shreg, bit_val_i);
        done_o    = is_last;
        if (bit_stb_i) cnt_nxt = is_last ? '0 : bit_cnt + 1'b1;
        else           cnt_nxt = bit_cnt;
        partial_o = (cnt_nxt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            bit_cnt <= flush_i ? '0 : cnt_nxt;
            if (bit_stb_i && (bit_cnt < BC_W'(DATA_W)))
                shreg <= {bit_val_i, shreg[DATA_W-1:1]};
        end
    end
endmodule

// File: rtl/rx_status.sv
module rx_status
    import strobe_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_err_i,
    input  logic              partial_i,
    input  logic              msg_start_i,
    input  logic              msg_end_i,
    input  logic              fifo_full_i,
    input  logic [CNT_W-1:0]  exp_count_i,
    input  logic [ERR_W-1:0]  clr_err_i,
    output logic              fifo_wr_o,
    output logic [DATA_W-1:0] fifo_data_o,
    output rx_err_t           err_o,
    output logic [CNT_W-1:0]  word_cnt_o,
    output logic              eom_o
);
    rx_err_t          set_e;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc   = (done_i && !(&word_cnt_o)) ? word_cnt_o + 1'b1 : word_cnt_o;
        set_e.par = done_i && par_err_i;
        set_e.ovr = done_i && fifo_full_i;
        set_e.frm = msg_end_i && partial_i;
        set_e.cnt = msg_end_i && (exp_count_i != '0) && (cnt_inc != exp_count_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr_o   <= 1'b0;
            fifo_data_o <= '0;
            err_o       <= '0;
            word_cnt_o  <= '0;
            eom_o       <= 1'b0;
        end else begin
            fifo_wr_o <= done_i && !fifo_full_i;
            if (done_i) fifo_data_o <= data_i;
            err_o      <= (err_o & ~rx_err_t'(clr_err_i)) | set_e;
            word_cnt_o <= msg_start_i ? '0 : cnt_inc;
            eom_o      <= msg_end_i;
        end
    end
endmodule

// File: rtl/strobe_word_rx.sv
module strobe_word_rx
    import strobe_rx_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_stb_i,
    input  logic              user_bit_i,
    input  logic [1:0]        par_mode_i,
    input  logic [CNT_W-1:0]  exp_count_i,
    input  logic [3:0]        clr_err_i,
    input  logic              fifo_full_i,
    output logic              fifo_wr_o,
    output logic [DATA_W-1:0] fifo_data_o,
    output logic [3:0]        err_o,
    output logic [CNT_W-1:0]  word_cnt_o,
    output logic              eom_irq_o,
    output logic              user_bit_o
);
    logic [3:0] raw_in, syn;
    logic       sclk_q, sdat_q, sstb_q;
    logic       sclk_d, sstb_d;
    logic       sclk_fall, stb_rise, stb_fall, bit_stb;
    logic       word_done, par_err, partial;
    logic [DATA_W-1:0] word_data;
    rx_err_t    err_s;

    assign raw_in = {user_bit_i, ser_stb_i, ser_dat_i, ser_clk_i};

    rx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(raw_in), .q_o(syn)
    );

    assign sclk_q     = syn[0];
    assign sdat_q     = syn[1];
    assign sstb_q     = syn[2];
    assign user_bit_o = syn[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            sstb_d <= 1'b0;
        end else begin
            sclk_d <= sclk_q;
            sstb_d <= sstb_q;
        end
    end

    assign sclk_fall = sclk_d && !sclk_q;
    assign stb_rise  = sstb_q && !sstb_d;
    assign stb_fall  = sstb_d && !sstb_q;
    // strobe as seen one sample earlier qualifies the bit
    assign bit_stb   = sclk_fall && sstb_d;

    rx_deframer #(.DATA_W(DATA_W)) u_defr (
        .clk(clk), .rst(rst),
        .bit_stb_i(bit_stb), .bit_val_i(sdat_q),
        .flush_i(stb_rise || stb_fall),
        .par_mode_i(par_mode_e'(par_mode_i)),
        .done_o(word_done), .data_o(word_data),
        .par_err_o(par_err), .partial_o(partial)
    );

    rx_status #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_stat (
        .clk(clk), .rst(rst),
        .done_i(word_done), .data_i(word_data), .par_err_i(par_err),
        .partial_i(partial), .msg_start_i(stb_rise), .msg_end_i(stb_fall),
        .fifo_full_i(fifo_full_i), .exp_count_i(exp_count_i),
        .clr_err_i(clr_err_i),
        .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o),
        .err_o(err_s), .word_cnt_o(word_cnt_o), .eom_o(eom_irq_o)
    );

    assign err_o = err_s;
endmodule

// File: rtl/strobe_word_rx_chk.sv
module strobe_word_rx_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_full_i,
    input logic             fifo_wr_o,
    input logic [3:0]       err_o,
    input logic [3:0]       clr_err_i,
    input logic             eom_irq_o,
    input logic [CNT_W-1:0] word_cnt_o,
    input logic             word_done,
    input logic             stb_rise,
    input logic             stb_fall,
    input logic             partial
);
    a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |-> !$past(fifo_full_i));

    a_r6_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (word_done && fifo_full_i) |=> err_o[2]);

    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (($past(err_o) & ~$past(clr_err_i) & ~err_o) == 4'b0000));

    a_r8_eom_single: assert property (@(posedge clk) disable iff (rst)
        eom_irq_o |=> !eom_irq_o);

    a_r9_count_cleared: assert property (@(posedge clk) disable iff (rst)
        stb_rise |=> (word_cnt_o == '0));

    a_r5_frame_flag: assert property (@(posedge clk) disable iff (rst)
        (stb_fall && partial) |=> err_o[1]);

    a_r2_write_spacing: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |=> !fifo_wr_o);
endmodule

bind strobe_word_rx strobe_word_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .fifo_full_i(fifo_full_i), .fifo_wr_o(fifo_wr_o),
    .err_o(err_o), .clr_err_i(clr_err_i), .eom_irq_o(eom_irq_o),
    .word_cnt_o(word_cnt_o), .word_done(word_done), .stb_rise(stb_rise),
    .stb_fall(stb_fall), .partial(partial)
);

// File: tb/strobe_word_rx_tb.sv
module strobe_word_rx_tb;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk_i = 1'b0, ser_dat_i = 1'b0, ser_stb_i = 1'b0, user_bit_i = 1'b0;
    logic [1:0]  par_mode_i = 2'd0;
    logic [15:0] exp_count_i = '0;
    logic [3:0]  clr_err_i = '0;
    logic        fifo_full_i = 1'b0;
    logic        fifo_wr_o, eom_irq_o, user_bit_o;
    logic [15:0] fifo_data_o, word_cnt_o;
    logic [3:0]  err_o;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [15:0] rx_q [1024];
    int rx_cnt = 0;
    int eom_seen = 0;
    logic [15:0] msg [8];

    always #2.5 clk = ~clk;

    strobe_word_rx u_dut (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
        .ser_stb_i(ser_stb_i), .user_bit_i(user_bit_i), .par_mode_i(par_mode_i),
        .exp_count_i(exp_count_i), .clr_err_i(clr_err_i), .fifo_full_i(fifo_full_i),
        .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o), .err_o(err_o),
        .word_cnt_o(word_cnt_o), .eom_irq_o(eom_irq_o), .user_bit_o(user_bit_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_wr_o) begin
                rx_q[rx_cnt % 1024] = fifo_data_o;
                rx_cnt++;
            end
            if (eom_irq_o) eom_seen++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic par_bit(input logic [1:0] pm, input logic [15:0] w);
        return (pm == 2'd1) ? ~(^w) : (^w);
    endfunction

    function automatic logic [3:0] exp_err(input int n, input logic [1:0] pm, input int bad,
                                           input int extra, input bit full, input int ec);
        logic [3:0] e;
        e[0] = (pm == 2'd1 || pm == 2'd2) && bad >= 0 && bad < n;
        e[1] = extra > 0;
        e[2] = full && n > 0;
        e[3] = ec != 0 && ec != n;
        return e;
    endfunction

    task automatic send_msg(input int n, input logic [1:0] pm, input int bad,
                            input int extra, input bit merge);
        logic bits [200];
        int nb = 0;
        bit pon = (pm == 2'd1 || pm == 2'd2);
        for (int w = 0; w < n; w++) begin
            for (int b = 0; b < 16; b++) begin bits[nb] = msg[w][b]; nb++; end
            if (pon) begin bits[nb] = par_bit(pm, msg[w]) ^ (w == bad); nb++; end
        end
        for (int x = 0; x < extra; x++) begin bits[nb] = x[0]; nb++; end
        par_mode_i = pm;
        @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            ser_clk_i = 1'b1; ser_dat_i = bits[i]; ser_stb_i = 1'b1;
            repeat (HALF) @(negedge clk);
            if (merge && i == nb - 1) ser_stb_i = 1'b0;
            ser_clk_i = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        if (!merge) begin
            ser_clk_i = 1'b1; ser_stb_i = 1'b0;
            repeat (HALF) @(negedge clk);
            ser_clk_i = 1'b0;
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic clear_all();
        clr_err_i = 4'hF; @(negedge clk); clr_err_i = 4'h0; @(negedge clk);
    endtask

    // One message, then check written words, count, flags, eom
    task automatic run_msg(input string tag, input int n, input logic [1:0] pm, input int bad,
                           input int extra, input bit full, input int ec, input bit merge);
        int base = rx_cnt;
        int eb = eom_seen;
        int nexp = full ? 0 : n;
        fifo_full_i = full;
        exp_count_i = 16'(ec);
        send_msg(n, pm, bad, extra, merge);
        fifo_full_i = 1'b0;
        chk({tag, " R1/R2/R6 words written"}, rx_cnt - base, nexp);
        for (int k = 0; k < nexp && k < rx_cnt - base; k++)
            chk({tag, " R1 word value"}, rx_q[(base + k) % 1024], msg[k]);
        chk({tag, " R9 word count"}, word_cnt_o, n);
        chk({tag, " R3/R5/R6/R7 error flags"}, err_o, exp_err(n, pm, bad, extra, full, ec));
        chk({tag, " R8 eom pulses"}, eom_seen - eb, 1);
        clear_all();
        chk({tag, " R4 flags cleared"}, err_o, 0);
    endtask

    initial begin
        void'($urandom(32'd4660));
        repeat (5) @(negedge clk);
        chk("R11 reset fifo_wr", fifo_wr_o, 0);
        chk("R11 reset err", err_o, 0);
        chk("R11 reset eom", eom_irq_o, 0);
        chk("R11 reset count", word_cnt_o, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // constrained random messages
        for (int it = 0; it < 10; it++) begin
            int n = 1 + ($urandom % 6);
            logic [1:0] pm = 2'($urandom % 4);
            int sel = $urandom % 3;
            int ec = (sel == 0) ? 0 : (sel == 1) ? n : n + 1;
            int bad = ($urandom % 3 == 0) ? int'($urandom % n) : -1;
            for (int w = 0; w < n; w++) msg[w] = 16'($urandom);
            run_msg("rand", n, pm, bad, 0, 1'b0, ec, 1'b0);
        end

        // directed corners
        msg[0] = 16'h0001; msg[1] = 16'h8000; msg[2] = 16'hA5C3;
        run_msg("R3 odd parity bad", 3, 2'd1, 1, 0, 1'b0, 0, 1'b0);
        run_msg("R3 even parity bad", 3, 2'd2, 0, 0, 1'b0, 0, 1'b0);
        run_msg("R3 mode3 off", 3, 2'd3, -1, 0, 1'b0, 0, 1'b0);
        run_msg("R5 frame partial", 2, 2'd0, -1, 5, 1'b0, 0, 1'b0);
        run_msg("R6 overrun", 3, 2'd1, -1, 0, 1'b1, 0, 1'b0);
        run_msg("R7 count short", 2, 2'd0, -1, 0, 1'b0, 3, 1'b0);
        run_msg("R12 merged end", 3, 2'd2, -1, 0, 1'b0, 3, 1'b1);
        run_msg("R12 merged end noparity", 2, 2'd0, -1, 0, 1'b0, 2, 1'b1);

        // R4: partial clear keeps the other flag
        exp_count_i = '0;
        send_msg(1, 2'd1, 0, 3, 1'b0);
        repeat (20) @(negedge clk);
        chk("R4 sticky after idle", err_o, 4'b0011);
        clr_err_i = 4'b0001; @(negedge clk); clr_err_i = 4'h0; @(negedge clk);
        chk("R4 masked clear", err_o, 4'b0010);
        clear_all();
        chk("R4 all cleared", err_o, 0);

        // R10 user bit
        user_bit_i = 1'b1; repeat (4) @(negedge clk);
        chk("R10 user bit high", user_bit_o, 1);
        user_bit_i = 1'b0; repeat (4) @(negedge clk);
        chk("R10 user bit low", user_bit_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule